// File: doc/BRIEF.md
# Cartridge ROM Bank-Switch Latch

This block sits on a host memory bus and answers reads in an 8 KB cartridge window, host addresses 0x6000 to 0x7FFF. Behind the window sits a 32 KB ROM. A two-bit bank register supplies the upper ROM address bits, so the window shows one of four 8 KB banks.

The host changes the bank by writing anywhere in the window. The bank number comes from two low address lines of that write. The data bus plays no part in it. Before every write the host performs a read of the same address. That read returns ROM data as usual and leaves the bank alone. Within one memory-enable low period the host may also flip its byte-select line. The read data then follows the new address on the next clock.

A parameter decides whether the latched bits drive the ROM directly or inverted. The ROM contents are computed from the index, so no table is stored.

Top module: `cart_bank_rom`

Address bit numbering below is conventional: bit 15 is the most significant and bit 0 is the byte-select line.

## Requirements
- R1: The block is selected when `mem_en_n` is 0 and `addr[15:13]` is 3'b011. On the clock edge where it is selected with `we_n` at 1, `rd_oe` becomes 1. On any other edge `rd_oe` becomes 0.
- R2: Let the effective bank be `eb` and let `idx` = {`eb`, `addr[12:0]`}, 15 bits. On an edge that sets `rd_oe`, `rd_data` is loaded with `idx[7:0] ^ idx[14:7] ^ 8'hA5`. This gives a read latency of one clock.
- R3: While `mem_en_n` stays 0, a change of `addr[0]` (or of any other window bit) shows in `rd_data` one clock later.
- R4: When `we_n` rises (it was 0 at the previous edge and is 1 now) while the block is selected, the bank register takes `addr[2:1]`.
- R5: When `we_n` rises while `mem_en_n` is 1, or while the address is outside the window, the bank register keeps its value.
- R6: A read cycle does not alter the bank register. This includes the read that precedes each write.
- R7: With `INVERT_BANK` = 0 the effective bank equals the bank register. With `INVERT_BANK` = 1 it is the bitwise complement of the register.
- R8: After reset, `rd_oe` is 0, `rd_data` is 0 and the bank register is 0. The first read therefore returns bank 0 data, or bank 3 data when the bank is inverted.
- R9: On an edge where `rd_oe` goes or stays 0, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Host address; bit 0 is byte select |
| mem_en_n | input | 1 | Active-low memory enable |
| we_n | input | 1 | Active-low write enable |
| rd_data | output | 8 | Registered ROM read data |
| rd_oe | output | 1 | Drive enable for the read data |

## Verification
The assertions assume the host holds the address and `mem_en_n` steady across the `we_n` rise. They also assume `we_n` is high whenever the host is not writing. The stimulus follows this rule. Every write is built as a read at the address, then a cycle with `we_n` low, then a cycle with `we_n` high while still selected, and only then a release of the bus. Random reads flip the byte-select line while `mem_en_n` stays low. Random writes land inside the window, outside it, or with `mem_en_n` high.

// File: rtl/cart_bank_rom.sv
module cart_bank_rom #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int BW          = 2,
  parameter int TAG_W       = 3,
  parameter logic [TAG_W-1:0] WIN_TAG = 3'b011,
  parameter int BANK_LSB    = 1,
  parameter logic [DW-1:0] PAT = 8'hA5,
  parameter bit INVERT_BANK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_en_n,
  input  logic          we_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe
);
  localparam int OFF_W = AW - TAG_W;
  localparam int IDX_W = OFF_W + BW;

  function automatic logic [DW-1:0] rom_word(input logic [IDX_W-1:0] i);
    return i[DW-1:0] ^ i[IDX_W-1 -: DW] ^ PAT;
  endfunction

  logic          we_q;
  logic [BW-1:0] bank_q;

  wire in_win = addr[AW-1 -: TAG_W] == WIN_TAG;
  wire sel    = !mem_en_n && in_win;
  wire rd_sel = sel && we_n;
  wire load   = sel && we_n && !we_q;

  wire [BW-1:0]    bank_eff = INVERT_BANK ? ~bank_q : bank_q;
  wire [IDX_W-1:0] idx      = {bank_eff, addr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      bank_q  <= '0;
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      we_q  <= we_n;
      rd_oe <= rd_sel;
      if (load)   bank_q  <= addr[BANK_LSB +: BW];
      if (rd_sel) rd_data <= rom_word(idx);
    end
  end

  p_oe_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && in_win && we_n) |=> rd_oe);
  p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_en_n && in_win && we_n) |=> !rd_oe);
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_en_n && in_win && we_n) |=> $stable(rd_data));
  p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && !we_q) |=> bank_q == $past(addr[BANK_LSB +: BW]));
  p_bank_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && $rose(we_n)) |=> $stable(bank_q));
endmodule

// File: tb/cart_bank_rom_test.sv
module cart_bank_rom_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic mem_en_n = 1'b1;
  logic we_n = 1'b1;
  logic [7:0] rd_data, rd_data_i;
  logic rd_oe, rd_oe_i;
  int total = 0, bad = 0;
  logic [1:0] ref_bank = 2'd0;

  always #4 clk = ~clk;

  cart_bank_rom uut (.clk(clk), .rst_n(rst_n), .addr(addr), .mem_en_n(mem_en_n),
                     .we_n(we_n), .rd_data(rd_data), .rd_oe(rd_oe));
  cart_bank_rom #(.INVERT_BANK(1'b1)) uut_inv (.clk(clk), .rst_n(rst_n), .addr(addr),
                     .mem_en_n(mem_en_n), .we_n(we_n), .rd_data(rd_data_i), .rd_oe(rd_oe_i));

  function automatic logic [7:0] exp_byte(input logic [1:0] b, input logic [15:0] a);
    logic [14:0] i;
    i = {b, a[12:0]};
    return i[7:0] ^ i[14:7] ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic men, input logic we);
    @(negedge clk);
    addr = a; mem_en_n = men; we_n = we;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_read(input string req, input logic [15:0] a);
    chk({req, " oe"}, {7'd0, rd_oe}, 8'd1);
    chk({req, " data"}, rd_data, exp_byte(ref_bank, a));
    chk({req, " R7 inv data"}, rd_data_i, exp_byte(~ref_bank, a));
  endtask

  task automatic do_write(input logic [15:0] a, input logic men);
    logic win;
    win = (a[15:13] == 3'b011) && !men;
    step(a, men, 1'b1);
    if (win) chk_read("R6 read-before-write", a);
    step(a, men, 1'b0);
    chk("R1 oe low during write", {7'd0, rd_oe}, 8'd0);
    step(a, men, 1'b1);
    if (win) ref_bank = a[2:1];
    step(16'h0000, 1'b1, 1'b1);
  endtask

  function automatic logic [15:0] rnd_win();
    logic [15:0] a;
    a = 16'($urandom);
    a[15:13] = 3'b011;
    return a;
  endfunction

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R8 reset state
    chk("R8 oe", {7'd0, rd_oe}, 8'd0);
    chk("R8 data", rd_data, 8'd0);
    step(16'h6000, 1'b0, 1'b1);
    chk_read("R8 first read bank0", 16'h6000);
    // R1 outside window and disabled
    step(16'h8000, 1'b0, 1'b1);
    chk("R1 outside oe", {7'd0, rd_oe}, 8'd0);
    chk("R9 hold data", rd_data, exp_byte(2'd0, 16'h6000));
    step(16'h6123, 1'b1, 1'b1);
    chk("R1 disabled oe", {7'd0, rd_oe}, 8'd0);
    // R3 mid-cycle byte select change
    step(16'h6ABD, 1'b0, 1'b1);
    chk_read("R3 odd byte", 16'h6ABD);
    step(16'h6ABC, 1'b0, 1'b1);
    chk_read("R3 even byte", 16'h6ABC);
    // R4 directed bank loads, bit 0 set to show it is ignored
    do_write(16'h7FF5, 1'b0);
    step(16'h6010, 1'b0, 1'b1);
    chk_read("R4 bank2", 16'h6010);
    do_write(16'h6003, 1'b0);
    step(16'h6010, 1'b0, 1'b1);
    chk_read("R4 bank1", 16'h6010);
    // R5 writes that must not load
    do_write(16'h5FF6, 1'b0);
    do_write(16'h6006, 1'b1);
    step(16'h6010, 1'b0, 1'b1);
    chk_read("R5 bank unchanged", 16'h6010);
    // random mix
    for (int n = 0; n < 800; n++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom_range(0, 3));
      case (op)
        0: begin
          a = rnd_win();
          a[0] = 1'b1;
          step(a, 1'b0, 1'b1);
          chk_read("R2 random read", a);
          a[0] = 1'b0;
          step(a, 1'b0, 1'b1);
          chk_read("R3 random switch", a);
          step(16'h0000, 1'b1, 1'b1);
          chk("R9 idle hold", rd_data, exp_byte(ref_bank, a));
        end
        1: do_write(rnd_win(), 1'b0);
        2: begin
          a = 16'($urandom);
          if (a[15:13] == 3'b011) a[15] = 1'b1;
          do_write(a, 1'b0);
        end
        default: do_write(rnd_win(), 1'b1);
      endcase
    end
    step(16'h7000, 1'b0, 1'b1);
    chk_read("R6 final bank", 16'h7000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule